// File: doc/BRIEF.md
# Model-Specific Register File With Write Filtering

This block is a per-core store of configuration registers addressed by a 32-bit register number. A write supplies a 64-bit value as two 32-bit halves. A read returns the selected register as a low half and a high half, registered, one cycle after the request. Each register applies its own write rule. Some registers keep only part of the value. Some accept a bit only when the matching feature input is set. Control registers take only all-zeros or all-ones values. The machine-check bank window grows or shrinks with the capability input. Numbers that decode to no register are ignored on write and read as zero.

The register set covers:
- three system-entry registers;
- an extended-feature-enable register;
- eight variable memory-type range pairs;
- eleven fixed memory-type range registers and a default memory-type register;
- machine-check global control and status;
- a parameterised number of machine-check banks of four registers each;
- three read-only registers: a performance-status constant, a memory-type capability word and the machine-check capability input.

The surrounding core drives the read and write strobes with the register number and takes the read halves on the following cycle. Any side effect of a register value on the rest of the core happens outside this block.

Top module: `msr_file`

## Requirements
- R1: A write on `wrEn` stores `{wrHi, wrLo}`. A read on `rdEn` presents the register's low 32 bits on `rdLo` and its high 32 bits on `rdHi` on the cycle after the request. The outputs hold between reads. A read and a write to the same number in one cycle return the value from before the write.
- R2: Register 0x174 (system-entry code segment) keeps bits 15:0 of a write, and its bits 63:16 read as zero.
- R3: Register 0xC000_0080 (feature enable) updates bit 0 only when `featEn[0]` is set, bit 8 only when `featEn[1]` is set, bit 14 only when `featEn[2]` is set, bit 11 only when `featEn[3]` is set, and bit 12 only when `featEn[4]` is set. Every other bit keeps its old value.
- R4: Variable-range pair n (n = 0..7) has its base at 0x200 + 2n and its mask at 0x201 + 2n. Each stores all 64 bits.
- R5: The fixed-range registers are 0x250, 0x258, 0x259 and 0x268..0x26F. The registers 0x2FF (default type), 0x175 and 0x176 (system-entry stack and entry point) and 0x17A (machine-check status) are also plain. All of these store all 64 bits.
- R6: Register 0x17B (machine-check control) accepts a write only when `mcgCap[8]` is set and the value is all zeros or all ones. It reads 0 while `mcgCap[8]` is clear.
- R7: Bank registers start at 0x400. An offset is live when it is below 4 × `mcgCap[7:0]` and below 4 × NUM_BANKS. A live offset with offset mod 4 = 0 accepts only all-zeros or all-ones; other live offsets accept any value. Offsets outside the window ignore writes and read 0.
- R8: A number that decodes to no register reads 0 and ignores writes. Writes to the read-only registers (0x198, 0xFE, 0x179) are ignored.
- R9: Register 0x198 reads as the constant 0x0000_0400_0000_03E8.
- R10: Register 0xFE reads 0x508 when `featEn[5]` is set and 0 otherwise. Register 0x179 reads the `mcgCap` input.
- R11: Reset clears every stored register and both read outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| regIdx | input | 32 | Register number |
| wrLo | input | 32 | Write data, bits 31:0 |
| wrHi | input | 32 | Write data, bits 63:32 |
| featEn | input | 6 | Feature enables: bits 4:0 gate the feature-enable register bits, bit 5 enables the memory-type capability word |
| mcgCap | input | 64 | Machine-check capability: bits 7:0 give the bank count, bit 8 means control is present |
| rdLo | output | 32 | Read data, bits 31:0 |
| rdHi | output | 32 | Read data, bits 63:32 |

## Verification
The feature-enable register is written with all ones under several feature patterns. The pattern of bits that change shows each feature gate on its own. Control and bank registers receive illegal patterns, all-zeros and all-ones, so that a value filter that is too loose or too strict shows up. The bank window is probed just inside and just outside the limit set by the capability byte, and again past the storage limit. A random stream of reads and writes over the known numbers, unknown numbers and read-only numbers, with changing feature and capability inputs, is compared against a behavioural model on every read.

// File: rtl/msr_pkg.sv
package msr_pkg;

  localparam int SLOT_W = 6;

  localparam logic [31:0] IDX_SE_CS    = 32'h0000_0174;
  localparam logic [31:0] IDX_SE_SP    = 32'h0000_0175;
  localparam logic [31:0] IDX_SE_IP    = 32'h0000_0176;
  localparam logic [31:0] IDX_FEATEN   = 32'hC000_0080;
  localparam logic [31:0] IDX_VAR0     = 32'h0000_0200;
  localparam logic [31:0] IDX_FIX64    = 32'h0000_0250;
  localparam logic [31:0] IDX_FIX16    = 32'h0000_0258;
  localparam logic [31:0] IDX_FIX4     = 32'h0000_0268;
  localparam logic [31:0] IDX_DEFTYPE  = 32'h0000_02FF;
  localparam logic [31:0] IDX_MTCAP    = 32'h0000_00FE;
  localparam logic [31:0] IDX_MCCAP    = 32'h0000_0179;
  localparam logic [31:0] IDX_MCSTAT   = 32'h0000_017A;
  localparam logic [31:0] IDX_MCCTL    = 32'h0000_017B;
  localparam logic [31:0] IDX_PERF     = 32'h0000_0198;
  localparam logic [31:0] IDX_BANK0    = 32'h0000_0400;

  localparam int VAR_REGS = 16;
  localparam int FIX_REGS = 11;

  localparam logic [63:0] PERF_CONST  = 64'h0000_0400_0000_03E8;
  localparam logic [63:0] MTCAP_CONST = 64'h0000_0000_0000_0508;

  // feature-enable register bit positions
  localparam int FE_SYSCALL = 0;
  localparam int FE_LONG    = 8;
  localparam int FE_NOEXEC  = 11;
  localparam int FE_VIRT    = 12;
  localparam int FE_FASTSV  = 14;

  typedef enum logic [3:0] {
    K_NONE, K_SECS, K_SESP, K_SEIP, K_FEATEN, K_VAR, K_FIX, K_DEF,
    K_MCCAP, K_MCSTAT, K_MCCTL, K_BANK, K_PERF, K_MTCAP
  } regKind_e;

  typedef struct packed {
    regKind_e            kind;
    logic [SLOT_W-1:0]   slot;
    logic                wrGo;
    logic                rdGo;
    logic [63:0]         keepMask;
  } msrStrobe_t;

endpackage

// File: rtl/msr_ctrl.sv
module msr_ctrl
  import msr_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [31:0] regIdx,
  input  logic [63:0] wrVal,
  input  logic [4:0]  featGate,
  input  logic [8:0]  capLow,
  output msrStrobe_t  stb
);

  localparam int BANK_REGS = 4 * NUM_BANKS;

  logic [31:0] varOff, fix16Off, fix4Off, bankOff, bankLimit;
  logic        allSame, bankLive, valOk;
  regKind_e    kind;
  logic [SLOT_W-1:0] slot;
  logic [63:0] updMask;

  assign varOff    = regIdx - IDX_VAR0;
  assign fix16Off  = regIdx - IDX_FIX16;
  assign fix4Off   = regIdx - IDX_FIX4;
  assign bankOff   = regIdx - IDX_BANK0;
  assign bankLimit = {22'd0, capLow[7:0], 2'b00};
  assign bankLive  = (regIdx >= IDX_BANK0) && (bankOff < bankLimit) &&
                     (bankOff < 32'(BANK_REGS));
  assign allSame   = (wrVal == 64'd0) || (&wrVal);

  // decode of the register number
  always_comb begin
    kind = K_NONE;
    slot = '0;
    if (regIdx == IDX_SE_CS)        kind = K_SECS;
    else if (regIdx == IDX_SE_SP)   kind = K_SESP;
    else if (regIdx == IDX_SE_IP)   kind = K_SEIP;
    else if (regIdx == IDX_FEATEN)  kind = K_FEATEN;
    else if (regIdx == IDX_DEFTYPE) kind = K_DEF;
    else if (regIdx == IDX_MCCAP)   kind = K_MCCAP;
    else if (regIdx == IDX_MCSTAT)  kind = K_MCSTAT;
    else if (regIdx == IDX_MCCTL)   kind = K_MCCTL;
    else if (regIdx == IDX_PERF)    kind = K_PERF;
    else if (regIdx == IDX_MTCAP)   kind = K_MTCAP;
    else if (regIdx >= IDX_VAR0 && varOff < 32'(VAR_REGS)) begin
      kind = K_VAR;
      slot = SLOT_W'(varOff);
    end else if (regIdx == IDX_FIX64) begin
      kind = K_FIX;
      slot = '0;
    end else if (regIdx >= IDX_FIX16 && fix16Off < 32'd2) begin
      kind = K_FIX;
      slot = SLOT_W'(fix16Off + 32'd1);
    end else if (regIdx >= IDX_FIX4 && fix4Off < 32'd8) begin
      kind = K_FIX;
      slot = SLOT_W'(fix4Off + 32'd3);
    end else if (bankLive) begin
      kind = K_BANK;
      slot = SLOT_W'(bankOff);
    end
  end

  // bits of the feature-enable register that a write may change
  always_comb begin
    updMask = '0;
    updMask[FE_SYSCALL] = featGate[0];
    updMask[FE_LONG]    = featGate[1];
    updMask[FE_FASTSV]  = featGate[2];
    updMask[FE_NOEXEC]  = featGate[3];
    updMask[FE_VIRT]    = featGate[4];
  end

  // per-register write filter
  always_comb begin
    case (kind)
      K_NONE, K_MCCAP, K_PERF, K_MTCAP: valOk = 1'b0;
      K_MCCTL: valOk = capLow[8] && allSame;
      K_BANK:  valOk = (slot[1:0] != 2'b00) || allSame;
      default: valOk = 1'b1;
    endcase
  end

  always_comb begin
    stb.kind = kind;
    stb.slot = slot;
    stb.wrGo = wrEn && valOk;
    stb.rdGo = rdEn;
    case (kind)
      K_FEATEN: stb.keepMask = ~updMask;
      K_SECS:   stb.keepMask = {{48{1'b1}}, 16'h0000};
      default:  stb.keepMask = '0;
    endcase
  end

endmodule

// File: rtl/msr_dpath.sv
module msr_dpath
  import msr_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  msrStrobe_t  stb,
  input  logic [63:0] wrVal,
  input  logic        mtcapOn,
  input  logic [63:0] mcgCap,
  output logic [31:0] rdLo,
  output logic [31:0] rdHi
);

  localparam int BANK_REGS = 4 * NUM_BANKS;
  localparam int BANK_W    = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1;

  logic [63:0] seCs, seSp, seIp, featReg, defType, mcStat, mcCtl;
  logic [63:0] varReg  [VAR_REGS];
  logic [63:0] fixReg  [FIX_REGS];
  logic [63:0] bankReg [BANK_REGS];
  logic [63:0] curVal, merged;
  logic [3:0]  vSlot, fSlot;
  logic [BANK_W-1:0] bSlot;

  assign vSlot = stb.slot[3:0];
  assign fSlot = stb.slot[3:0];
  assign bSlot = stb.slot[BANK_W-1:0];

  // value of the selected register as seen by a read
  always_comb begin
    case (stb.kind)
      K_SECS:   curVal = seCs;
      K_SESP:   curVal = seSp;
      K_SEIP:   curVal = seIp;
      K_FEATEN: curVal = featReg;
      K_VAR:    curVal = varReg[vSlot];
      K_FIX:    curVal = fixReg[fSlot];
      K_DEF:    curVal = defType;
      K_MCCAP:  curVal = mcgCap;
      K_MCSTAT: curVal = mcStat;
      K_MCCTL:  curVal = mcgCap[8] ? mcCtl : 64'd0;
      K_BANK:   curVal = bankReg[bSlot];
      K_PERF:   curVal = PERF_CONST;
      K_MTCAP:  curVal = mtcapOn ? MTCAP_CONST : 64'd0;
      default:  curVal = 64'd0;
    endcase
  end

  assign merged = (curVal & stb.keepMask) | (wrVal & ~stb.keepMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seCs    <= '0;
      seSp    <= '0;
      seIp    <= '0;
      featReg <= '0;
      defType <= '0;
      mcStat  <= '0;
      mcCtl   <= '0;
      for (int i = 0; i < VAR_REGS; i++)  varReg[i]  <= '0;
      for (int i = 0; i < FIX_REGS; i++)  fixReg[i]  <= '0;
      for (int i = 0; i < BANK_REGS; i++) bankReg[i] <= '0;
    end else if (stb.wrGo) begin
      case (stb.kind)
        K_SECS:   seCs    <= merged;
        K_SESP:   seSp    <= merged;
        K_SEIP:   seIp    <= merged;
        K_FEATEN: featReg <= merged;
        K_VAR:    varReg[vSlot]  <= merged;
        K_FIX:    fixReg[fSlot]  <= merged;
        K_DEF:    defType <= merged;
        K_MCSTAT: mcStat  <= merged;
        K_MCCTL:  mcCtl   <= merged;
        K_BANK:   bankReg[bSlot] <= merged;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdLo <= '0;
      rdHi <= '0;
    end else if (stb.rdGo) begin
      rdLo <= curVal[31:0];
      rdHi <= curVal[63:32];
    end
  end

  AST_CS_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    seCs[63:16] == 48'd0); // R2

  AST_FEATEN_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrGo && stb.kind == K_FEATEN) |=>
      (((featReg ^ $past(featReg)) & $past(stb.keepMask)) == 64'd0)); // R3

  AST_MCCTL_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (mcCtl == 64'd0) || (&mcCtl)); // R6

  AST_UNKNOWN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdGo && stb.kind == K_NONE) |=> (rdLo == 32'd0 && rdHi == 32'd0)); // R8

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdGo |=> ($stable(rdLo) && $stable(rdHi))); // R1

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBankChk
    AST_BANK_CTL_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
      (bankReg[4*g] == 64'd0) || (&bankReg[4*g])); // R7
  end

endmodule

// File: rtl/msr_file.sv
module msr_file
  import msr_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [31:0] regIdx,
  input  logic [31:0] wrLo,
  input  logic [31:0] wrHi,
  input  logic [5:0]  featEn,
  input  logic [63:0] mcgCap,
  output logic [31:0] rdLo,
  output logic [31:0] rdHi
);

  msrStrobe_t  stb;
  logic [63:0] wrVal;

  assign wrVal = {wrHi, wrLo};

  initial begin
    if (NUM_BANKS < 1 || 4 * NUM_BANKS > (1 << SLOT_W))
      $error("NUM_BANKS out of range");
  end

  msr_ctrl #(.NUM_BANKS(NUM_BANKS)) uCtrl (
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .regIdx   (regIdx),
    .wrVal    (wrVal),
    .featGate (featEn[4:0]),
    .capLow   (mcgCap[8:0]),
    .stb      (stb)
  );

  msr_dpath #(.NUM_BANKS(NUM_BANKS)) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrVal   (wrVal),
    .mtcapOn (featEn[5]),
    .mcgCap  (mcgCap),
    .rdLo    (rdLo),
    .rdHi    (rdHi)
  );

endmodule

// File: tb/sim_msr_file.sv
module sim_msr_file;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [31:0] regIdx = '0, wrLo = '0, wrHi = '0;
  logic [5:0]  featEn = '0;
  logic [63:0] mcgCap = '0;
  logic [31:0] rdLo, rdHi;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit [63:0] mem [int unsigned];

  always #(CLK_PERIOD/2) clk = ~clk;

  msr_file #(.NUM_BANKS(NB)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regIdx(regIdx),
    .wrLo(wrLo), .wrHi(wrHi), .featEn(featEn), .mcgCap(mcgCap),
    .rdLo(rdLo), .rdHi(rdHi)
  );

  // ---------------- behavioural reference ----------------
  function automatic bit isPlain(int unsigned i);
    if (i inside {32'h174, 32'h175, 32'h176, 32'h2FF, 32'h17A, 32'h250,
                  32'h258, 32'h259}) return 1;
    if (i >= 32'h200 && i < 32'h210) return 1;
    if (i >= 32'h268 && i < 32'h270) return 1;
    return 0;
  endfunction

  function automatic bit bankLive(int unsigned i);
    int unsigned off;
    if (i < 32'h400) return 0;
    off = i - 32'h400;
    return (off < 4 * mcgCap[7:0]) && (off < 4 * NB);
  endfunction

  function automatic bit [63:0] mGet(int unsigned i);
    return mem.exists(i) ? mem[i] : 64'd0;
  endfunction

  function automatic bit [63:0] mRead(int unsigned i);
    if (i == 32'h198) return 64'h0000_0400_0000_03E8;
    if (i == 32'hFE)  return featEn[5] ? 64'h508 : 64'd0;
    if (i == 32'h179) return mcgCap;
    if (i == 32'h17B) return mcgCap[8] ? mGet(i) : 64'd0;
    if (i == 32'hC000_0080) return mGet(i);
    if (isPlain(i)) return mGet(i);
    if (bankLive(i)) return mGet(i);
    return 64'd0;
  endfunction

  function automatic void mWrite(int unsigned i, bit [63:0] v);
    bit legal = (v == 64'd0) || (v == '1);
    bit [63:0] u = '0;
    if (i == 32'h174) mem[i] = v & 64'hFFFF;
    else if (i == 32'hC000_0080) begin
      u[0] = featEn[0]; u[8] = featEn[1]; u[14] = featEn[2];
      u[11] = featEn[3]; u[12] = featEn[4];
      mem[i] = (mGet(i) & ~u) | (v & u);
    end else if (isPlain(i)) mem[i] = v;
    else if (i == 32'h17B) begin
      if (mcgCap[8] && legal) mem[i] = v;
    end else if (bankLive(i)) begin
      if (((i - 32'h400) % 4) != 0 || legal) mem[i] = v;
    end
  endfunction

  // ---------------- stimulus helpers ----------------
  // one cycle: optional write and/or read; read checked after the edge
  task automatic step(bit w, bit r, int unsigned i, bit [63:0] v, string tag);
    bit [63:0] exp;
    exp = mRead(i);
    if (w) mWrite(i, v);
    wrEn = w; rdEn = r; regIdx = i; {wrHi, wrLo} = v;
    @(negedge clk);
    wrEn = 0; rdEn = 0;
    if (r) begin
      checks++;
      if ({rdHi, rdLo} !== exp) begin
        errors++;
        $display("FAIL %s idx=%h actual=%h expected=%h", tag, i, {rdHi, rdLo}, exp);
      end
    end
  endtask

  task automatic wr(int unsigned i, bit [63:0] v, string tag);
    step(1, 0, i, v, tag);
  endtask

  task automatic rd(int unsigned i, string tag);
    step(0, 1, i, 64'd0, tag);
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  int unsigned pool [] = '{32'h174, 32'h175, 32'h176, 32'hC000_0080, 32'h200,
    32'h205, 32'h20F, 32'h250, 32'h258, 32'h259, 32'h268, 32'h26F, 32'h2FF,
    32'hFE, 32'h179, 32'h17A, 32'h17B, 32'h198, 32'h400, 32'h401, 32'h404,
    32'h40C, 32'h40F, 32'h410, 32'h1234, 32'h270};

  initial begin
    mem.delete();
    mcgCap = 64'h104;
    repeat (3) @(negedge clk);
    // R11: reset outputs and storage
    checks++;
    if ({rdHi, rdLo} !== 64'd0) begin
      errors++;
      $display("FAIL R11 outputs actual=%h expected=0", {rdHi, rdLo});
    end
    rstN = 1;
    @(negedge clk);
    rd(32'h174, "R11"); rd(32'hC000_0080, "R11"); rd(32'h207, "R11");
    rd(32'h26A, "R11"); rd(32'h17B, "R11"); rd(32'h40D, "R11");

    // R1: full-width write and readback, same-cycle read sees old value
    wr(32'h175, 64'h0123_4567_89AB_CDEF, "R1");
    rd(32'h175, "R1");
    step(1, 1, 32'h175, 64'hFEDC_BA98_7654_3210, "R1");
    rd(32'h175, "R1");
    // R1: outputs hold while no read is issued
    wr(32'h176, 64'h5555_AAAA_5555_AAAA, "R1");
    checks++;
    if ({rdHi, rdLo} !== 64'hFEDC_BA98_7654_3210) begin
      errors++;
      $display("FAIL R1 hold actual=%h expected=%h", {rdHi, rdLo}, 64'hFEDC_BA98_7654_3210);
    end
    rd(32'h176, "R5");

    // R2
    wr(32'h174, '1, "R2");
    rd(32'h174, "R2");

    // R3: feature gating of the enable register
    featEn = 6'b000000; wr(32'hC000_0080, '1, "R3"); rd(32'hC000_0080, "R3");
    featEn = 6'b000011; wr(32'hC000_0080, '1, "R3"); rd(32'hC000_0080, "R3");
    featEn = 6'b011100; wr(32'hC000_0080, '1, "R3"); rd(32'hC000_0080, "R3");
    featEn = 6'b000001; wr(32'hC000_0080, 64'd0, "R3"); rd(32'hC000_0080, "R3");

    // R4: interleaved pairs
    for (int n = 0; n < 8; n++) begin
      wr(32'h200 + 2*n, 64'h1111_0000_0000_0000 * (n + 1) + n, "R4");
      wr(32'h201 + 2*n, 64'hA000_0000_0000_0F00 + n, "R4");
    end
    for (int n = 0; n < 16; n++) rd(32'h200 + n, "R4");

    // R5: fixed range and other plain registers
    wr(32'h250, 64'h0606_0606_0606_0606, "R5");
    wr(32'h258, 64'h0505_0505_0505_0505, "R5");
    wr(32'h259, 64'h0404_0404_0404_0404, "R5");
    for (int n = 0; n < 8; n++) wr(32'h268 + n, 64'h0100_0000_0000_0000 * n + 7, "R5");
    wr(32'h2FF, 64'hC06, "R5"); wr(32'h17A, 64'h8000_0000_0000_0005, "R5");
    rd(32'h250, "R5"); rd(32'h258, "R5"); rd(32'h259, "R5");
    for (int n = 0; n < 8; n++) rd(32'h268 + n, "R5");
    rd(32'h2FF, "R5"); rd(32'h17A, "R5");

    // R6: machine-check control
    mcgCap = 64'h004; wr(32'h17B, '1, "R6"); rd(32'h17B, "R6");
    mcgCap = 64'h104; rd(32'h17B, "R6");
    wr(32'h17B, 64'h1234, "R6"); rd(32'h17B, "R6");
    wr(32'h17B, '1, "R6"); rd(32'h17B, "R6");
    mcgCap = 64'h004; rd(32'h17B, "R6");
    mcgCap = 64'h104; wr(32'h17B, 64'd0, "R6"); rd(32'h17B, "R6");

    // R7: bank window and control filter
    mcgCap = 64'h102;
    wr(32'h400, 64'h5, "R7"); rd(32'h400, "R7");
    wr(32'h400, '1, "R7"); rd(32'h400, "R7");
    wr(32'h401, 64'h5, "R7"); rd(32'h401, "R7");
    wr(32'h407, 64'h77, "R7"); rd(32'h407, "R7");
    wr(32'h408, 64'h0, "R7"); wr(32'h409, 64'h99, "R7"); rd(32'h409, "R7");
    mcgCap = 64'h104; rd(32'h409, "R7");
    mcgCap = 64'h1FF; wr(32'h411, 64'h42, "R7"); rd(32'h411, "R7");
    mcgCap = 64'h101; rd(32'h401, "R7"); rd(32'h407, "R7");
    mcgCap = 64'h104;

    // R8: unknown and read-only
    wr(32'h1234, '1, "R8"); rd(32'h1234, "R8"); rd(32'hC000_0081, "R8");
    wr(32'h198, 64'd0, "R8"); wr(32'hFE, 64'd0, "R8"); wr(32'h179, 64'd0, "R8");
    // R9 / R10
    rd(32'h198, "R9");
    featEn = 6'b100000; rd(32'hFE, "R10");
    featEn = 6'b000000; rd(32'hFE, "R10");
    mcgCap = 64'hDEAD_0000_0000_0104; rd(32'h179, "R10");
    mcgCap = 64'h104;

    // R1: random stream compared against the model on every read
    for (int k = 0; k < 600; k++) begin
      int unsigned i = pool[$urandom_range(0, pool.size() - 1)];
      bit [63:0] v;
      case ($urandom_range(0, 3))
        0: v = 64'd0;
        1: v = '1;
        default: v = {$urandom(), $urandom()};
      endcase
      if (k % 50 == 0) begin
        featEn = 6'($urandom());
        mcgCap = {56'd0, 8'($urandom_range(0, 6))} | (64'($urandom_range(0, 1)) << 8);
      end
      step($urandom_range(0, 1), 1, i, v, "R1");
    end

    done = 1;
    finishRun();
  end

endmodule